// File: doc/BRIEF.md
# Write Status Polling Logic

This block forms the word the host reads back while a program or erase operation is under way inside a non-volatile memory, so that software can tell when the operation has finished without a separate ready pin. A timer elsewhere raises a busy level for the whole internal operation and a second level telling whether it is a whole-chip erase. The block keeps the address and data of the most recent word loaded before the operation began. It also watches host read strobes together with the array word already fetched for the read address.

While the device is idle, every read returns the array word unchanged. While busy, the block inserts two status signals into the word. In each byte lane, bit 7 of the lane carries the complement of the true value of the last loaded word when the read address matches that word's address. During a chip erase it carries 0, the complement of the erased value, at any address. Bit 6 of each lane is driven from one toggle flip-flop that inverts on every busy read, whatever the address. All other bits still come from the array. The analog output enable and high-impedance behaviour are reduced to a one-cycle valid flag.

Top module: `write_status_poll`

## Requirements
- R1: After reset, rd_valid_o is 0, rd_data_o is all zeros and the toggle state is 0.
- R2: A read strobe rd_i in one cycle gives rd_valid_o high for exactly the next cycle with the read result on rd_data_o; rd_valid_o is low after any cycle without a strobe.
- R3: When busy_i is low at the read strobe, rd_data_o equals array_data_i sampled at the strobe.
- R4: When busy_i is high, erase_i is low and rd_addr_i equals the last loaded address, bits 7 and 15 of the result are the complement of bits 7 and 15 of the last loaded data.
- R5: When busy_i and erase_i are both high, bits 7 and 15 of the result are 0 at any address.
- R6: When busy_i is high, bits 6 and 14 of the result are equal and carry the toggle state before the read; each busy read then inverts the toggle state, at any address.
- R7: Reads while busy_i is low leave the toggle state unchanged, as seen at the next busy read.
- R8: While busy_i is high, bits other than 6, 7, 14 and 15 equal array_data_i; bits 7 and 15 also equal array_data_i when erase_i is low and the address does not match the last loaded address.
- R9: A load strobe load_i while busy_i is high is ignored: the stored last word stays as it was.
- R10: A load strobe while busy_i is low replaces the stored address and data, so the last of several loads is the one polled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Internal program or erase running |
| erase_i | input | 1 | Running operation is a chip erase |
| load_i | input | 1 | Word load strobe |
| load_addr_i | input | 16 | Address of the loaded word |
| load_data_i | input | 16 | Data of the loaded word |
| rd_i | input | 1 | Host read strobe |
| rd_addr_i | input | 16 | Host read address |
| array_data_i | input | 16 | Array word at rd_addr_i |
| rd_data_o | output | 16 | Read result |
| rd_valid_o | output | 1 | Read result valid, one cycle |

## Verification
The bench sweeps patterns of the array word and of the loaded data through idle, program and erase reads. It watches the toggle bit across idle gaps, because a design that advanced the toggle on idle reads, or never advanced it, breaks the strict alternation the host relies on. Reads at a non-matching address during programming catch a design that complements the status bits everywhere. A load attempted while busy catches a design that lets the polled word shift under the host. Erase reads catch a design that complements stale data instead of reporting the erased value.

// File: rtl/poll_pkg.sv
package poll_pkg;
  localparam int unsigned LANE_W   = 8;
  localparam int unsigned POLL_BIT = 7;  // complemented-data status bit in each lane
  localparam int unsigned TGL_BIT  = 6;  // toggle status bit in each lane

  function automatic int unsigned lane_count(int unsigned data_w);
    return data_w / LANE_W;
  endfunction
endpackage

// File: rtl/poll_last_word.sv
module poll_last_word #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic [ADDR_W-1:0] last_addr_o,
  output logic [DATA_W-1:0] last_data_o
);
  logic cap;
  assign cap = load_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_addr_o <= '0;
      last_data_o <= '0;
    end else if (cap) begin
      last_addr_o <= load_addr_i;
      last_data_o <= load_data_i;
    end
  end

  p_hold_while_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(last_data_o) && $stable(last_addr_o)));
  p_capture_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !busy_i) |=> (last_data_o == $past(load_data_i)));
endmodule

// File: rtl/poll_toggle.sv
module poll_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic rd_i,
  output logic tgl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              tgl_o <= 1'b0;
    else if (busy_i && rd_i)  tgl_o <= ~tgl_o;
  end

  p_flip_on_busy_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && rd_i) |=> (tgl_o != $past(tgl_o)));
  p_hold_otherwise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_i && rd_i) |=> $stable(tgl_o));
endmodule

// File: rtl/poll_read_mux.sv
module poll_read_mux
  import poll_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] array_data_i,
  input  logic [DATA_W-1:0] last_data_i,
  input  logic              busy_i,
  input  logic              erase_i,
  input  logic              addr_hit_i,
  input  logic              tgl_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int unsigned LANES = lane_count(DATA_W);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar b = 0; b < LANE_W; b++) begin : g_bit
      localparam int unsigned IDX = l * LANE_W + b;
      if (b == POLL_BIT) begin : g_poll
        always_comb begin
          if (!busy_i)         word_o[IDX] = array_data_i[IDX];
          else if (erase_i)    word_o[IDX] = 1'b0;  // complement of erased ones
          else if (addr_hit_i) word_o[IDX] = ~last_data_i[IDX];
          else                 word_o[IDX] = array_data_i[IDX];
        end
      end else if (b == TGL_BIT) begin : g_tgl
        assign word_o[IDX] = busy_i ? tgl_i : array_data_i[IDX];
      end else begin : g_pass
        assign word_o[IDX] = array_data_i[IDX];
      end
    end
  end
endmodule

// File: rtl/write_status_poll.sv
module write_status_poll
  import poll_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              erase_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  localparam int unsigned LANES = lane_count(DATA_W);
  localparam int unsigned TOP_T = (LANES - 1) * LANE_W + TGL_BIT;

  logic [ADDR_W-1:0] last_addr;
  logic [DATA_W-1:0] last_data;
  logic [DATA_W-1:0] word;
  logic              tgl;
  logic              hit;
  logic              rd_busy_q;

  poll_last_word #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_last (
    .clk_i, .rst_ni, .busy_i, .load_i, .load_addr_i, .load_data_i,
    .last_addr_o(last_addr), .last_data_o(last_data)
  );

  poll_toggle i_tgl (.clk_i, .rst_ni, .busy_i, .rd_i, .tgl_o(tgl));

  assign hit = (rd_addr_i == last_addr);

  poll_read_mux #(.DATA_W(DATA_W)) i_mux (
    .array_data_i, .last_data_i(last_data), .busy_i, .erase_i,
    .addr_hit_i(hit), .tgl_i(tgl), .word_o(word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
      rd_busy_q  <= 1'b0;
    end else begin
      rd_valid_o <= rd_i;
      if (rd_i) begin
        rd_data_o <= word;
        rd_busy_q <= busy_i;
      end
    end
  end

  p_valid_after_rd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rd_valid_o);
  p_no_valid_without_rd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rd_valid_o);
  p_idle_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !busy_i) |=> (rd_data_o == $past(array_data_i)));
  p_erase_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && busy_i && erase_i) |=> (rd_data_o[POLL_BIT] == 1'b0));
  p_lanes_equal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_busy_q) |-> (rd_data_o[TGL_BIT] == rd_data_o[TOP_T]));
endmodule

// File: tb/test_write_status_poll.sv
module test_write_status_poll;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        busy_i = 1'b0, erase_i = 1'b0, load_i = 1'b0, rd_i = 1'b0;
  logic [15:0] load_addr_i = '0, load_data_i = '0, rd_addr_i = '0, array_data_i = '0;
  logic [15:0] rd_data_o;
  logic        rd_valid_o;

  int n_cmp = 0, n_bad = 0;
  logic        m_tgl = 1'b0;
  logic [15:0] m_addr = '0, m_data = '0;
  bit          done = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  write_status_poll i_write_status_poll (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_word(logic [15:0] arr, logic [15:0] addr);
    logic [15:0] r = arr;
    if (busy_i) begin
      r[6] = m_tgl; r[14] = m_tgl;
      if (erase_i) begin r[7] = 1'b0; r[15] = 1'b0; end
      else if (addr == m_addr) begin r[7] = ~m_data[7]; r[15] = ~m_data[15]; end
    end
    return r;
  endfunction

  task automatic load(logic [15:0] a, logic [15:0] d);
    @(negedge clk_i);
    load_i = 1'b1; load_addr_i = a; load_data_i = d;
    @(negedge clk_i);
    load_i = 1'b0;
    if (!busy_i) begin m_addr = a; m_data = d; end
  endtask

  task automatic rd(string req, logic [15:0] addr, logic [15:0] arr);
    logic [15:0] e;
    @(negedge clk_i);
    rd_i = 1'b1; rd_addr_i = addr; array_data_i = arr;
    e = expect_word(arr, addr);
    if (busy_i) m_tgl = ~m_tgl;
    @(negedge clk_i);
    rd_i = 1'b0;
    check({req, " valid"}, {15'd0, rd_valid_o}, 16'd1);
    check(req, rd_data_o, e);
  endtask

  initial begin
    #25;
    check("R1 valid", {15'd0, rd_valid_o}, 16'd0);
    check("R1 data", rd_data_o, 16'd0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
    check("R2 no read", {15'd0, rd_valid_o}, 16'd0);

    // R3: idle pass-through sweep
    for (int i = 0; i < 64; i++) rd("R3 idle", 16'(i * 3), 16'(i * 16'h0413 + 16'h8001));
    @(negedge clk_i);
    check("R2 valid drop", {15'd0, rd_valid_o}, 16'd0);

    // R4 R6 R8 R10: program polling over data patterns
    for (int p = 0; p < 16; p++) begin
      logic [15:0] d = 16'(p * 16'h1111) ^ 16'h8040;
      load(16'h0100 + 16'(p), 16'hFFFF);
      load(16'h0200 + 16'(p), d);       // R10: last load wins
      @(negedge clk_i) busy_i = 1'b1;
      load(16'h0300, ~d);               // R9: ignored while busy
      for (int k = 0; k < 3; k++) rd("R4 R6 hit", 16'h0200 + 16'(p), 16'(k * 16'h2D2D + p));
      rd("R8 miss", 16'h0100 + 16'(p), 16'hA5A5 ^ 16'(p));
      rd("R8 miss", 16'h0300, 16'h5A5A);
      @(negedge clk_i) busy_i = 1'b0;
      rd("R7 idle", 16'h0000, 16'(p * 16'h0F0F));
      rd("R7 idle", 16'h0001, 16'hFFFF);
    end

    // R5: chip erase polling at several addresses
    @(negedge clk_i); busy_i = 1'b1; erase_i = 1'b1;
    for (int i = 0; i < 12; i++) rd("R5 R6 erase", 16'(i * 16'h1555), 16'(i * 16'h3C3C + 16'h8080));
    @(negedge clk_i); busy_i = 1'b0; erase_i = 1'b0;
    rd("R3 after", 16'h0000, 16'hFFFF);

    // R6 R7: toggle phase across busy windows with idle reads between
    for (int w = 0; w < 4; w++) begin
      @(negedge clk_i) busy_i = 1'b1;
      rd("R6 window", 16'h4000, 16'h0000);
      @(negedge clk_i) busy_i = 1'b0;
      for (int j = 0; j < w; j++) rd("R7 gap", 16'h4000, 16'h1234);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule